// File: doc/BRIEF.md
# Multi-Rail Enable Mode Controller

This block decides, for a group of supply channels (three by default), when each channel's power switch may be turned on. It sits between the qualified comparator flags and the per-channel startup/fault sequencer. It produces one enable request per channel, and it produces a one-cycle unlatch pulse when a channel's latched fault is cleared.

Three operating modes are supported. In tracking mode all rails come up and go down together. In sequencing mode each rail follows its own on-request, but any fault shuts every rail. In independent mode each rail is fully isolated from the others. The mode is captured from a two-bit select while no channel is enabled and undervoltage lockout is satisfied. It is then frozen for as long as any channel stays enabled.

The on-request and power-ready flags are asynchronous to the block and pass through two-flop synchronizers. The UVLO and fault flags arrive synchronous to the clock.

Top module: `rail_enable_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, en_o and unlatch_o are all zero, and the captured mode is sequencing.
- R2: mode_sel_i decodes as 2'b00 = independent, 2'b11 = tracking, 2'b01 or 2'b10 = sequencing.
- R3: In tracking mode every en_o bit is 1 only when uvlo_ok_i is 1, all pgood_i are 1, all on_req_i are 1 and no channel has a fault; otherwise every en_o bit is 0.
- R4: In sequencing mode en_o[i] is 1 when uvlo_ok_i is 1, all pgood_i are 1, on_req_i[i] is 1 and no channel has a fault.
- R5: In independent mode en_o[i] is 1 when uvlo_ok_i, pgood_i[i] and on_req_i[i] are all 1 and channel i has no fault.
- R6: A fault_i[i] high at a clock edge forces en_o[i] low after that edge. In tracking and sequencing modes it forces all en_o low; in independent mode the other channels are unaffected.
- R7: A fault is latched until cleared. A falling on-request clears the latch. In tracking and sequencing modes a fall on any channel clears every latch; in independent mode it clears only that channel's latch. unlatch_o[i] pulses high for exactly one cycle on the edge where channel i's latch clears, which is the third clock edge after on_req_i falls.
- R8: The mode is loaded from mode_sel_i only while all en_o are 0 and uvlo_ok_i is 1. A select change while any channel is enabled has no effect until all channels are off.
- R9: A change on on_req_i or pgood_i reaches en_o on the third clock edge after it is applied. It has no effect on the first two edges.
- R10: uvlo_ok_i low at a clock edge forces all en_o to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uvlo_ok_i | input | 1 | Undervoltage lockout satisfied (synchronous) |
| mode_sel_i | input | 2 | Mode select: 00 independent, 11 tracking, else sequencing |
| pgood_i | input | N_CH | Per-channel input power-ready (asynchronous) |
| on_req_i | input | N_CH | Per-channel on-request (asynchronous) |
| fault_i | input | N_CH | Per-channel fault flag (synchronous) |
| en_o | output | N_CH | Per-channel enable request to the startup sequencer |
| unlatch_o | output | N_CH | One-cycle pulse when a channel's fault latch clears |

## Verification
The bench sweeps every select code against every combination of power-ready, on-request and UVLO. A decoder that mixed up the two sequencing codes, or a sequencing rule that tested only the channel's own power-ready, would show up as wrong enables in this sweep.

Directed runs cover the following cases:
- Fault scope in each mode. A design that leaked a fault into other channels in independent mode, or kept the others running in sequencing mode, fails here.
- Latch clearing by a request on a different channel. A design that cleared the wrong latch in independent mode, or cleared only the cycled channel in the shared modes, fails here.
- Exact synchronizer latency, and the exact cycle of the unlatch pulse.
- A select change while rails are up. A controller that switched modes at once would drop a sequenced rail.

// File: rtl/rail_mode_pkg.sv
package rail_mode_pkg;
  typedef enum logic [1:0] {
    MODE_INDEP = 2'd0,
    MODE_SEQ   = 2'd1,
    MODE_TRACK = 2'd2
  } rail_mode_e;

  // select pin: low -> independent, high -> tracking, open/mid -> sequencing
  function automatic rail_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return MODE_INDEP;
      2'b11:   return MODE_TRACK;
      default: return MODE_SEQ;
    endcase
  endfunction
endpackage

// File: rtl/rail_sync_2ff.sv
module rail_sync_2ff #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rail_fault_latch.sv
module rail_fault_latch #(
  parameter int N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shared_i,
  input  logic [N_CH-1:0] on_s_i,
  input  logic [N_CH-1:0] fault_i,
  output logic [N_CH-1:0] flt_o,
  output logic [N_CH-1:0] unlatch_o
);
  logic [N_CH-1:0] on_d_q, flt_q, unl_q;
  logic [N_CH-1:0] fall, clr;

  assign fall = on_d_q & ~on_s_i;
  assign clr  = shared_i ? {N_CH{|fall}} : fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_d_q <= '0;
      flt_q  <= '0;
      unl_q  <= '0;
    end else begin
      on_d_q <= on_s_i;
      // set dominates clear: an active fault keeps the latch
      flt_q  <= fault_i | (flt_q & ~clr);
      unl_q  <= flt_q & clr & ~fault_i;
    end
  end

  assign flt_o     = flt_q;
  assign unlatch_o = unl_q;

  p_unlatch_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unl_q) |=> ((unl_q & $past(unl_q)) == '0));

  p_unlatch_after_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unl_q) |-> ((unl_q & flt_q) == '0));
endmodule

// File: rtl/rail_enable_logic.sv
module rail_enable_logic
  import rail_mode_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  rail_mode_e      mode_i,
  input  logic            uvlo_ok_i,
  input  logic [N_CH-1:0] pg_i,
  input  logic [N_CH-1:0] on_i,
  input  logic [N_CH-1:0] flt_i,
  output logic [N_CH-1:0] en_o
);
  logic all_pg, all_on, any_flt;

  assign all_pg  = &pg_i;
  assign all_on  = &on_i;
  assign any_flt = |flt_i;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_comb begin
      unique case (mode_i)
        MODE_TRACK: en_o[i] = uvlo_ok_i & all_pg & all_on & ~any_flt;
        MODE_SEQ:   en_o[i] = uvlo_ok_i & all_pg & on_i[i] & ~any_flt;
        default:    en_o[i] = uvlo_ok_i & pg_i[i] & on_i[i] & ~flt_i[i];
      endcase
    end
  end
endmodule

// File: rtl/rail_enable_ctrl.sv
module rail_enable_ctrl
  import rail_mode_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            uvlo_ok_i,
  input  logic [1:0]      mode_sel_i,
  input  logic [N_CH-1:0] pgood_i,
  input  logic [N_CH-1:0] on_req_i,
  input  logic [N_CH-1:0] fault_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] unlatch_o
);
  localparam int SYNC_W = 2 * N_CH;

  logic [SYNC_W-1:0] sync_out;
  logic [N_CH-1:0]   pg_s, on_s, flt_l, flt_eff, en_d, en_q;
  rail_mode_e        mode_q, mode_eff;
  logic              mode_load;

  rail_sync_2ff #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pgood_i, on_req_i}),
    .q_o   (sync_out)
  );
  assign on_s = sync_out[N_CH-1:0];
  assign pg_s = sync_out[SYNC_W-1:N_CH];

  // mode sampled only while every rail is off and UVLO is met
  assign mode_load = uvlo_ok_i & ~(|en_q);
  assign mode_eff  = mode_load ? decode_mode(mode_sel_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SEQ;
    else         mode_q <= mode_eff;
  end

  rail_fault_latch #(.N_CH(N_CH)) u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shared_i (mode_eff != MODE_INDEP),
    .on_s_i   (on_s),
    .fault_i  (fault_i),
    .flt_o    (flt_l),
    .unlatch_o(unlatch_o)
  );

  assign flt_eff = flt_l | fault_i;

  rail_enable_logic #(.N_CH(N_CH)) u_en (
    .mode_i   (mode_eff),
    .uvlo_ok_i(uvlo_ok_i),
    .pg_i     (pg_s),
    .on_i     (on_s),
    .flt_i    (flt_eff),
    .en_o     (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  p_uvlo_kill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uvlo_ok_i |=> (en_q == '0));

  p_fault_kill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_i) |=> ((en_q & $past(fault_i)) == '0));

  p_shared_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_eff != MODE_INDEP) && (|fault_i)) |=> (en_q == '0));

  p_track_uniform_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TRACK) |-> ((en_q == '0) || (&en_q)));

  p_mode_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_q) |=> $stable(mode_q));

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> ((en_q == '0) && (unlatch_o == '0)));
endmodule

// File: tb/rail_enable_ctrl_tb.sv
`timescale 1ns/1ps
module rail_enable_ctrl_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0;
  logic [1:0] sel = 2'b01;
  logic [N-1:0] pg = '0, onr = '0, flt = '0;
  logic [N-1:0] en, unl;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rail_enable_ctrl #(.N_CH(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_ok_i(uvlo), .mode_sel_i(sel),
    .pgood_i(pg), .on_req_i(onr), .fault_i(flt), .en_o(en), .unlatch_o(unl)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic u, input logic [1:0] s, input logic [N-1:0] p,
                       input logic [N-1:0] o, input logic [N-1:0] f);
    @(negedge clk);
    uvlo = u; sel = s; pg = p; onr = o; flt = f;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // mode: 0 independent, 1 sequencing, 2 tracking
  function automatic logic [N-1:0] model(input int m, input logic u,
                                         input logic [N-1:0] p, input logic [N-1:0] o);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (m == 2)      r[i] = u & (&p) & (&o);
      else if (m == 1) r[i] = u & (&p) & o[i];
      else             r[i] = u & p[i] & o[i];
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 reset en", en, '0);
    chk("R1 reset unlatch", unl, '0);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    chk("R1 post-reset en", en, '0);

    // R2 R3 R4 R5: sweep every select code and input pattern
    for (int s = 0; s < 4; s++) begin
      int m;
      m = (s == 0) ? 0 : ((s == 3) ? 2 : 1);
      for (int p = 0; p < 8; p++)
        for (int o = 0; o < 8; o++)
          for (int u = 0; u < 2; u++) begin
            drive(1'b0, s[1:0], p[N-1:0], o[N-1:0], '0);
            edges(3);
            drive(u[0], s[1:0], p[N-1:0], o[N-1:0], '0);
            edges(2);
            chk($sformatf("R2/R3/R4/R5 sel=%0d pg=%0d on=%0d uvlo=%0d", s, p, o, u),
                en, model(m, u[0], p[N-1:0], o[N-1:0]));
          end
    end

    // sequencing, all up
    drive(1'b0, 2'b01, '1, '1, '0); edges(3);
    drive(1'b1, 2'b01, '1, '1, '0); edges(4);
    chk("R4 seq all up", en, 3'b111);

    // R9 latency of on-request
    drive(1'b1, 2'b01, '1, 3'b110, '0);
    edges(2);
    chk("R9 no change after two edges", en, 3'b111);
    edges(1);
    chk("R9 change on third edge", en, 3'b110);
    drive(1'b1, 2'b01, '1, '1, '0); edges(4);

    // R6 R7 sequencing fault kills all, shared clear
    drive(1'b1, 2'b01, '1, '1, 3'b010);
    edges(1);
    chk("R6 seq fault kills all", en, 3'b000);
    drive(1'b1, 2'b01, '1, '1, '0); edges(4);
    chk("R7 seq fault latched", en, 3'b000);
    drive(1'b1, 2'b01, '1, 3'b011, '0);
    edges(2);
    chk("R7 no unlatch before third edge", unl, 3'b000);
    edges(1);
    chk("R7 seq unlatch by other channel", unl, 3'b010);
    edges(1);
    chk("R7 unlatch one cycle", unl, 3'b000);
    drive(1'b1, 2'b01, '1, '1, '0); edges(4);
    chk("R7 seq restart", en, 3'b111);

    // R8 mode frozen while enabled
    drive(1'b1, 2'b01, '1, 3'b001, '0); edges(4);
    chk("R8 seq single rail", en, 3'b001);
    drive(1'b1, 2'b11, '1, 3'b001, '0); edges(4);
    chk("R8 select change ignored while on", en, 3'b001);
    drive(1'b1, 2'b11, '1, 3'b000, '0); edges(4);
    chk("R8 all off", en, 3'b000);
    drive(1'b1, 2'b11, '1, 3'b001, '0); edges(4);
    chk("R8 tracking now captured", en, 3'b000);
    drive(1'b1, 2'b11, '1, '1, '0); edges(4);
    chk("R3 tracking all up", en, 3'b111);

    // R6 R7 tracking fault
    drive(1'b1, 2'b11, '1, '1, 3'b100);
    edges(1);
    chk("R6 track fault kills all", en, 3'b000);
    drive(1'b1, 2'b11, '1, '1, '0); edges(4);
    chk("R7 track fault latched", en, 3'b000);
    drive(1'b1, 2'b11, '1, 3'b110, '0);
    edges(3);
    chk("R7 track unlatch", unl, 3'b100);
    drive(1'b1, 2'b11, '1, '1, '0); edges(4);
    chk("R7 track restart", en, 3'b111);

    // independent mode
    drive(1'b0, 2'b00, '1, '1, '0); edges(3);
    chk("R10 uvlo low off", en, 3'b000);
    drive(1'b1, 2'b00, '1, '1, '0); edges(4);
    chk("R5 indep all up", en, 3'b111);
    drive(1'b1, 2'b00, '1, '1, 3'b001);
    edges(1);
    chk("R6 indep fault isolated", en, 3'b110);
    drive(1'b1, 2'b00, '1, '1, '0); edges(4);
    chk("R7 indep latched", en, 3'b110);
    drive(1'b1, 2'b00, '1, 3'b101, '0);
    edges(3);
    chk("R7 indep other channel no unlatch", unl, 3'b000);
    edges(1);
    chk("R7 indep other channel off", en, 3'b100);
    drive(1'b1, 2'b00, '1, '1, '0); edges(4);
    chk("R7 indep latch kept", en, 3'b110);
    drive(1'b1, 2'b00, '1, 3'b110, '0);
    edges(3);
    chk("R7 indep own unlatch", unl, 3'b001);
    drive(1'b1, 2'b00, '1, '1, '0); edges(4);
    chk("R7 indep restart", en, 3'b111);

    // R9 pgood latency in independent mode
    drive(1'b1, 2'b00, 3'b011, '1, '0);
    edges(2);
    chk("R9 pgood two edges", en, 3'b111);
    edges(1);
    chk("R9 pgood third edge", en, 3'b011);

    // R10 uvlo loss acts on next edge
    drive(1'b0, 2'b00, '1, '1, '0);
    edges(1);
    chk("R10 uvlo kill", en, 3'b000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule